// File: doc/BRIEF.md
# Retriggerable Clocked One-Shot

This block turns an event on its trigger inputs into one output pulse whose length is counted in clock cycles. Two trigger inputs and an active-low clear are sampled through a two-flop stage and edge-detected inside the block. Three combinations start a pulse: a rising edge on the second input while the first is low, a falling edge on the first input while the second is high, or a rising edge on the clear while the first input is low and the second is high. The pulse and its complement are both registered outputs.

Each accepted trigger opens a short guard phase of `DEAD_CYCLES` cycles in which further triggers are ignored. A timing phase follows, and in it a new trigger reloads the full width so the pulse carries on without a gap. The width comes from the `width` input and is captured at the accepted trigger. Holding the clear low drops the output at once, resets the timing state and blocks all triggers.

Top module: `retrig_oneshot`

## Requirements
- R1: After the synchronous reset `rst_n`, with no trigger, `pulse_q` is 0 and `pulse_qn` is 1.
- R2: With `trig_a` low, a rising edge on `trig_b` starts a pulse; `pulse_q` goes high after the third rising clock edge that follows the input change.
- R3: With `trig_b` high, a falling edge on `trig_a` starts a pulse with the same three-edge latency.
- R4: With `trig_a` low and `trig_b` high, a rising edge on `clr_n` starts a pulse with the same three-edge latency.
- R5: A rising `trig_b` while `trig_a` is high, and a falling `trig_a` while `trig_b` is low, start nothing.
- R6: A pulse lasts exactly max(`width`, `DEAD_CYCLES`+1) clock cycles after the last accepted trigger; `width` values 0 and 1 are raised to that minimum.
- R7: A trigger reaching the timer on any of the `DEAD_CYCLES` edges right after an accepted trigger is ignored; the pulse end does not move.
- R8: A trigger reaching the timer after the guard phase restarts the full width, with `pulse_q` staying high, including when it lands on the very cycle the pulse would otherwise end.
- R9: While `clr_n` is low, `pulse_q` is forced low without waiting for a clock and every trigger is ignored.
- R10: `pulse_qn` is always the inverse of `pulse_q`.
- R11: `width` is captured when a trigger is accepted; changing it during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Active-low clear, asynchronous on the timer; its rising edge can trigger |
| trig_a | input | 1 | Trigger input, falling-edge active |
| trig_b | input | 1 | Trigger input, rising-edge active |
| width | input | WIDTH_W | Pulse length in clock cycles |
| pulse_q | output | 1 | Registered pulse output |
| pulse_qn | output | 1 | Registered complement of pulse_q |

## Verification
Pulse expiry and a retrigger can fall on the same clock edge: the remaining count sits at one just as a new trigger reaches the timer. The bench times a second rising edge on `trig_b` so that, through the three-edge input path, it lands exactly on that last cycle, and judges the result by requiring an unbroken high output that ends a full width after the retrigger edge. The close of the guard phase meets a retrigger in the same way, so triggers landing on the last guard edge and on the first edge after it are driven and their opposite outcomes compared.

// File: rtl/oneshot_pkg.sv
// Shared types for the retriggerable one-shot.
// Assumes: nothing beyond SystemVerilog 2017.
package oneshot_pkg;

    // Timer phase: resting, guard after a trigger, and timing out the width.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DEAD = 2'd1,
        PH_TIME = 2'd2
    } os_phase_e;

endpackage

// File: rtl/os_edge_sync.sv
// Two-flop synchronizer followed by a one-cycle history flop.
// Provides the synchronized level and its value one cycle earlier so an
// edge detector can compare them.
// Assumes: din may be asynchronous; RST_VAL is chosen so that leaving reset
// does not fabricate the edge a downstream detector looks for.
module os_edge_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prev
);

    logic meta_q;
    logic sync_q;
    logic hist_q;

    // Synchronize the input and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            hist_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign prev = hist_q;

endmodule

// File: rtl/os_trig_cond.sv
// Decodes the three trigger conditions from synchronized levels.
// Assumes: all inputs come from os_edge_sync instances on the same clock.
module os_trig_cond (
    input  logic a_lvl,
    input  logic a_prev,
    input  logic b_lvl,
    input  logic b_prev,
    input  logic c_lvl,
    input  logic c_prev,
    output logic fire
);

    logic b_rise;
    logic a_fall;
    logic c_rise;
    logic hit_b;
    logic hit_a;
    logic hit_c;

    // Edge detection on each synchronized input.
    always_comb begin
        b_rise = b_lvl & ~b_prev;
        a_fall = ~a_lvl & a_prev;
        c_rise = c_lvl & ~c_prev;
    end

    // Qualify each edge with the level of the other inputs; clear gates all.
    always_comb begin
        hit_b = ~a_lvl & b_rise;
        hit_a = b_lvl & a_fall;
        hit_c = ~a_lvl & b_lvl & c_rise;
        fire  = c_lvl & (hit_a | hit_b | hit_c);
    end

endmodule

// File: rtl/os_timer.sv
// Pulse timer: guard phase, then timing phase, driven by a down-counter.
// Each accepted trigger loads the clamped width and the guard length; triggers
// are refused during the guard phase. Outputs are registered.
// Assumes: clr_n is an active-low asynchronous clear, rst_n synchronous;
// DEAD_CYCLES + 1 fits in WIDTH_W bits.
module os_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int DEAD_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               fire,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse_q,
    output logic               pulse_qn,
    output os_phase_e          phase_o,
    output logic [WIDTH_W-1:0] remain_o
);

    localparam int                 DEAD_W  = (DEAD_CYCLES > 0) ? $clog2(DEAD_CYCLES + 1) : 1;
    localparam logic [WIDTH_W-1:0] MIN_W   = WIDTH_W'(DEAD_CYCLES + 1);
    localparam logic [DEAD_W-1:0]  DEAD_LD = DEAD_W'(DEAD_CYCLES);
    localparam os_phase_e          START_PH = (DEAD_CYCLES > 0) ? PH_DEAD : PH_TIME;

    os_phase_e          phase_q, phase_d;
    logic [WIDTH_W-1:0] remain_q, remain_d;
    logic [DEAD_W-1:0]  dead_q, dead_d;
    logic [WIDTH_W-1:0] eff_w;
    logic               accept;

    // Raise short widths to the minimum and decide whether a trigger counts.
    always_comb begin
        eff_w  = (width > MIN_W) ? width : MIN_W;
        accept = fire && (phase_q != PH_DEAD);
    end

    // Next-state logic for phase and counters.
    always_comb begin
        phase_d  = phase_q;
        remain_d = remain_q;
        dead_d   = dead_q;
        if (accept) begin
            remain_d = eff_w;
            dead_d   = DEAD_LD;
            phase_d  = START_PH;
        end else begin
            case (phase_q)
                PH_DEAD: begin
                    remain_d = remain_q - 1'b1;
                    dead_d   = dead_q - 1'b1;
                    if (dead_q == DEAD_W'(1)) begin
                        phase_d = PH_TIME;
                    end
                end
                PH_TIME: begin
                    remain_d = remain_q - 1'b1;
                    if (remain_q == WIDTH_W'(1)) begin
                        phase_d = PH_IDLE;
                    end
                end
                default: begin
                    remain_d = '0;
                    dead_d   = '0;
                end
            endcase
        end
    end

    // State and output registers; clear acts at once, reset on the clock.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            phase_q  <= PH_IDLE;
            remain_q <= '0;
            dead_q   <= '0;
            pulse_q  <= 1'b0;
            pulse_qn <= 1'b1;
        end else if (!rst_n) begin
            phase_q  <= PH_IDLE;
            remain_q <= '0;
            dead_q   <= '0;
            pulse_q  <= 1'b0;
            pulse_qn <= 1'b1;
        end else begin
            phase_q  <= phase_d;
            remain_q <= remain_d;
            dead_q   <= dead_d;
            pulse_q  <= (phase_d != PH_IDLE);
            pulse_qn <= (phase_d == PH_IDLE);
        end
    end

    assign phase_o  = phase_q;
    assign remain_o = remain_q;

endmodule

// File: rtl/retrig_oneshot.sv
// Retriggerable one-shot top: synchronizes the trigger and clear inputs,
// decodes the trigger conditions and drives the pulse timer.
// Assumes: trig_a, trig_b and clr_n may be asynchronous to clk; width is
// stable around the edge where a trigger is accepted.
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int DEAD_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               trig_a,
    input  logic               trig_b,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse_q,
    output logic               pulse_qn
);

    localparam int               NSIG     = 3;
    // Bit 0 trig_a, bit 1 trig_b, bit 2 clr_n.
    localparam logic [NSIG-1:0]  SYNC_RST = 3'b110;

    logic [NSIG-1:0]    raw;
    logic [NSIG-1:0]    lvl;
    logic [NSIG-1:0]    prev;
    logic               fire;
    os_phase_e          tmr_phase;
    logic [WIDTH_W-1:0] tmr_remain;

    assign raw = {clr_n, trig_b, trig_a};

    // One synchronizer per sampled input.
    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        os_edge_sync #(
            .RST_VAL (SYNC_RST[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[g]),
            .lvl   (lvl[g]),
            .prev  (prev[g])
        );
    end

    os_trig_cond u_cond (
        .a_lvl  (lvl[0]),
        .a_prev (prev[0]),
        .b_lvl  (lvl[1]),
        .b_prev (prev[1]),
        .c_lvl  (lvl[2]),
        .c_prev (prev[2]),
        .fire   (fire)
    );

    os_timer #(
        .WIDTH_W     (WIDTH_W),
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .fire     (fire),
        .width    (width),
        .pulse_q  (pulse_q),
        .pulse_qn (pulse_qn),
        .phase_o  (tmr_phase),
        .remain_o (tmr_remain)
    );

endmodule

// File: rtl/os_checker.sv
// Property checker for retrig_oneshot, attached with bind.
// Assumes: clr_n is not pulsed shorter than one clock period.
module os_checker
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_n,
    input logic               fire,
    input logic               pulse_q,
    input logic               pulse_qn,
    input os_phase_e          phase,
    input logic [WIDTH_W-1:0] remain
);

    assert_rise_from_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        $rose(pulse_q) |-> $past(fire))
        else $error("pulse rose without a trigger");

    assert_end_on_count_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ($fell(pulse_q) && $past(clr_n)) |-> ($past(remain) == WIDTH_W'(1)))
        else $error("pulse ended before the count ran out");

    assert_guard_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (phase == PH_DEAD) |=> (remain == $past(remain) - 1'b1))
        else $error("trigger changed the count during the guard phase");

    assert_retrigger_holds_R8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (phase == PH_TIME && fire) |=> pulse_q)
        else $error("retrigger let the pulse drop");

    assert_clear_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !pulse_q)
        else $error("pulse high while clear is low");

    assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_qn == !pulse_q)
        else $error("complement output out of step");

endmodule

bind retrig_oneshot os_checker #(
    .WIDTH_W (WIDTH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .fire     (fire),
    .pulse_q  (pulse_q),
    .pulse_qn (pulse_qn),
    .phase    (tmr_phase),
    .remain   (tmr_remain)
);

// File: tb/retrig_oneshot_tb.sv
`timescale 1ns/1ps
module retrig_oneshot_tb;

    localparam int WW = 8;
    localparam int DC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_n = 1'b1;
    logic          a = 1'b1;
    logic          b = 1'b0;
    logic [WW-1:0] width = 8'd10;
    logic          q;
    logic          qn;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    logic rec [0:255];

    always #2.5 clk = ~clk;

    retrig_oneshot #(.WIDTH_W(WW), .DEAD_CYCLES(DC)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .trig_a(a), .trig_b(b),
        .width(width), .pulse_q(q), .pulse_qn(qn)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock; sample at the falling edge and check the complement (R10).
    task automatic stepc();
        @(negedge clk);
        if (idx < 255) idx++;
        rec[idx] = q;
        chk(qn === ~q, "R10", "pulse_qn vs ~pulse_q", int'(qn), int'(~q));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) stepc();
    endtask

    // Compare recorded samples 1..upto with a high window [start, start+len).
    task automatic expect_window(input int start, input int len, input int upto,
                                 input string tag);
        int first_hi = -1;
        int hi_cnt = 0;
        bit ok = 1'b1;
        for (int i = 1; i <= upto; i++) begin
            bit want = (i >= start) && (i < start + len);
            if (rec[i] === 1'b1) begin
                hi_cnt++;
                if (first_hi < 0) first_hi = i;
            end
            if (rec[i] !== want) ok = 1'b0;
        end
        chk(ok, tag, "pulse start", first_hi, (len > 0) ? start : -1);
        chk(ok, tag, "pulse length", hi_cnt, len);
    endtask

    task automatic t_reset();
        steps(2);
        chk(q === 1'b0, "R1", "pulse_q after reset", int'(q), 0);
        chk(qn === 1'b1, "R1", "pulse_qn after reset", int'(qn), 1);
    endtask

    task automatic t_b_rise();
        a = 1'b0; steps(4);
        idx = 0; b = 1'b1; steps(20);
        expect_window(3, 10, 20, "R2 B rise with A low (R6 width 10)");
        b = 1'b0; steps(2); a = 1'b1; steps(6);
    endtask

    task automatic t_a_fall();
        idx = 0; b = 1'b1; steps(10);
        expect_window(0, 0, 10, "R5 B rise with A high");
        idx = 0; a = 1'b0; steps(20);
        expect_window(3, 10, 20, "R3 A fall with B high");
        b = 1'b0; steps(2); a = 1'b1; steps(6);
    endtask

    task automatic t_ignore();
        idx = 0; a = 1'b0; steps(10);
        expect_window(0, 0, 10, "R5 A fall with B low");
        a = 1'b1; steps(4);
    endtask

    task automatic t_clear_rise();
        b = 1'b1; steps(5);
        clr_n = 1'b0; steps(4);
        idx = 0; a = 1'b0; steps(12);
        expect_window(0, 0, 12, "R9 A fall ignored while clear low");
        idx = 0; clr_n = 1'b1; steps(20);
        expect_window(3, 10, 20, "R4 clear rise with A low B high");
        a = 1'b1; steps(2); b = 1'b0; steps(6);
    endtask

    task automatic t_clamp();
        width = 8'd1; a = 1'b0; steps(4);
        idx = 0; b = 1'b1; steps(12);
        expect_window(3, DC + 1, 12, "R6 width 1 raised to minimum");
        b = 1'b0; steps(8);
        width = 8'd0;
        idx = 0; b = 1'b1; steps(12);
        expect_window(3, DC + 1, 12, "R6 width 0 raised to minimum");
        width = 8'd10; b = 1'b0; steps(2); a = 1'b1; steps(6);
    endtask

    // Trigger lands on the last guard edge (7): ignored.
    task automatic t_dead_last();
        a = 1'b0; steps(4);
        idx = 0; b = 1'b1; steps(3);
        b = 1'b0; steps(1);
        b = 1'b1; steps(16);
        expect_window(3, 10, 20, "R7 retrigger on last guard edge");
        b = 1'b0; steps(8);
    endtask

    // Trigger lands on the first edge after the guard (8): restarts.
    task automatic t_dead_after();
        idx = 0; b = 1'b1; steps(4);
        b = 1'b0; steps(1);
        b = 1'b1; steps(19);
        expect_window(3, 15, 24, "R8 retrigger first edge after guard");
        b = 1'b0; steps(8);
    endtask

    // Trigger lands on the edge where the pulse would end (13).
    task automatic t_retrig_last();
        idx = 0; b = 1'b1; steps(9);
        b = 1'b0; steps(1);
        b = 1'b1; steps(20);
        expect_window(3, 20, 30, "R8 retrigger on expiry cycle");
        b = 1'b0; steps(8);
    endtask

    task automatic t_width_hold();
        idx = 0; b = 1'b1; steps(5);
        width = 8'd3; steps(15);
        expect_window(3, 10, 20, "R11 width change mid-pulse");
        width = 8'd10; b = 1'b0; steps(8);
    endtask

    task automatic t_clear_mid();
        idx = 0; b = 1'b1; steps(6);
        chk(q === 1'b1, "R9", "pulse high before clear", int'(q), 1);
        clr_n = 1'b0; #1;
        chk(q === 1'b0, "R9", "pulse_q right after clear falls", int'(q), 0);
        chk(qn === 1'b1, "R9", "pulse_qn right after clear falls", int'(qn), 1);
        b = 1'b0; steps(2);
        idx = 0; b = 1'b1; steps(8);
        expect_window(0, 0, 8, "R9 B rise ignored while clear low");
        a = 1'b1; steps(4);
        idx = 0; clr_n = 1'b1; steps(12);
        expect_window(0, 0, 12, "R9 no pulse after clear with A high");
        b = 1'b0; steps(6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_b_rise();
        t_a_fall();
        t_ignore();
        t_clear_rise();
        t_clamp();
        t_dead_last();
        t_dead_after();
        t_retrig_last();
        t_width_hold();
        t_clear_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule